// File: doc/BRIEF.md
# Three-Channel Reload Timer

A byte-wide, memory-mapped peripheral holding three down-counters. All three share one tick enable. Each counter reloads its fixed start value on the step where it would reach zero. On that reload it can latch an interrupt flag. Software sees eight byte offsets. Offset 1 is a second control register on write and a flag status register on read. Offset 0 is a control register whose destination is steered by a select bit kept in offset 1. Reading a timer's low-byte offset acknowledges that timer's flag.

The counters stay frozen after reset until software writes the steered control register with its run bit at 0. From then on they run for good. A single interrupt line is the OR of the three flags. Read data is registered and appears on `rd_data` in the cycle after the read strobe.

Top module: `tri_reload_timer`

## Requirements
- R1: After reset, `irq` is 0. Every flag, interrupt enable, the select bit and the run state are clear. Each counter holds its reload value (defaults 32, 3200 and 801).
- R2: Before the run state is set, tick pulses change no counter and set no flag.
- R3: A write to offset 1 stores data bit 0 as the select bit and data bit 6 as timer 2's interrupt enable.
- R4: A write to offset 0 with select = 1 stores bit 6 as timer 1's interrupt enable. If data bit 0 is 0, the same write sets the run state. The run state stays set until reset.
- R5: A write to offset 0 with select = 0 stores bit 6 as timer 3's interrupt enable and does not touch the run state.
- R6: Once running, each counter steps down by one per tick and reloads on the tick that takes it to zero. Timer k therefore reloads after every RELOAD_k ticks.
- R7: A reload sets that timer's flag only when its interrupt enable is 1.
- R8: A read of offset 1 returns flags of timers 1, 2 and 3 in bits 0, 1 and 2 with bits 7..3 zero, and leaves the flags unchanged.
- R9: A read of offset 3, 5 or 7 clears the flag of timer 1, 2 or 3. Reads of offsets 0, 2, 3, 4, 5, 6 and 7 return 0x00.
- R10: If a flag is cleared by a read in the same cycle its timer sets it, the flag ends up set.
- R11: `irq` is 1 exactly when at least one flag is set.
- R12: Writes to offsets 2 to 7 change no enable, select bit, run state or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable shared by all three counters |
| acc_en | input | 1 | Register access strobe, one cycle per access |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 3 | Byte offset 0..7 |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data, valid the cycle after a read |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions treat each access as a single-cycle strobe. A flag may fall only when the preceding cycle carried a read of its own low-byte offset. A flag may rise only on a running tick. The stimulus drives each access for exactly one cycle and lets `tick` overlap an access only in the deliberate set-versus-clear collision case. Expected flag patterns come from the bench's own count of ticks since start, compared against each timer's period.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NUM_TMR  = 3;
  localparam int ADDR_W   = 3;
  localparam int DATA_W   = 8;
  localparam int SEL_BIT  = 0;
  localparam int RUNN_BIT = 0;
  localparam int IE_BIT   = 6;
  localparam logic [ADDR_W-1:0] OFS_CTRL_SH = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_CTRL_ST = 3'd1;

  function automatic logic [ADDR_W-1:0] low_ofs(input int idx);
    return ADDR_W'(2 * idx + 3);
  endfunction
endpackage

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int CNT_W  = 16,
  parameter int RELOAD = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  input  logic ie,
  input  logic clr,
  output logic flag
);
  localparam logic [CNT_W-1:0] RLD = CNT_W'(RELOAD);

  logic [CNT_W-1:0] cnt_q;
  logic             step;
  logic             wrap;

  assign step = run && tick;
  assign wrap = step && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= RLD;
    end else if (step) begin
      cnt_q <= wrap ? RLD : cnt_q - CNT_W'(1);
    end
  end

  // set beats clear when both occur together
  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
    end else if (wrap && ie) begin
      flag <= 1'b1;
    end else if (clr) begin
      flag <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [NUM_TMR-1:0] flags,
  output logic [DATA_W-1:0] rd_data,
  output logic [NUM_TMR-1:0] ie,
  output logic              running,
  output logic [NUM_TMR-1:0] clr
);
  logic rd_stb;
  logic wr_stb;
  logic sel_q;
  logic unused_wbits;

  assign rd_stb = acc_en && !acc_wr;
  assign wr_stb = acc_en && acc_wr;
  assign unused_wbits = ^{wr_data[DATA_W-1], wr_data[IE_BIT-1:1]};

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_clr
    assign clr[i] = rd_stb && (acc_addr == low_ofs(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= 1'b0;
      ie      <= '0;
      running <= 1'b0;
    end else if (wr_stb) begin
      if (acc_addr == OFS_CTRL_ST) begin
        sel_q <= wr_data[SEL_BIT];
        ie[1] <= wr_data[IE_BIT];
      end else if (acc_addr == OFS_CTRL_SH) begin
        if (sel_q) begin
          ie[0] <= wr_data[IE_BIT];
          if (!wr_data[RUNN_BIT]) running <= 1'b1;
        end else begin
          ie[2] <= wr_data[IE_BIT];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_stb) begin
      rd_data <= (acc_addr == OFS_CTRL_ST) ? DATA_W'(flags) : '0;
    end
  end
endmodule

// File: rtl/tri_reload_timer.sv
module tri_reload_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int RELOAD_T1 = 32,
  parameter int RELOAD_T2 = 3200,
  parameter int RELOAD_T3 = 801
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  localparam int RLD [NUM_TMR] = '{RELOAD_T1, RELOAD_T2, RELOAD_T3};

  logic [NUM_TMR-1:0] flags;
  logic [NUM_TMR-1:0] ie;
  logic [NUM_TMR-1:0] clr;
  logic               running;

  tmr_regs u_regs (
    .clk      (clk),
    .rst      (rst),
    .acc_en   (acc_en),
    .acc_wr   (acc_wr),
    .acc_addr (acc_addr),
    .wr_data  (wr_data),
    .flags    (flags),
    .rd_data  (rd_data),
    .ie       (ie),
    .running  (running),
    .clr      (clr)
  );

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_chan
    tmr_chan #(
      .CNT_W  (CNT_W),
      .RELOAD (RLD[i])
    ) u_chan (
      .clk  (clk),
      .rst  (rst),
      .run  (running),
      .tick (tick),
      .ie   (ie[i]),
      .clr  (clr[i]),
      .flag (flags[i])
    );
  end

  assign irq = |flags;
endmodule

// File: rtl/tri_reload_timer_chk.sv
module tri_reload_timer_chk
  import tmr_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               tick,
  input logic               acc_en,
  input logic               acc_wr,
  input logic [ADDR_W-1:0]  acc_addr,
  input logic [DATA_W-1:0]  rd_data,
  input logic               irq,
  input logic               running,
  input logic [NUM_TMR-1:0] flags
);
  // R2
  idle_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
    !running |-> flags == '0);

  // R4
  run_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !$fell(running));

  // R9
  rd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_en && !acc_wr && acc_addr != OFS_CTRL_ST) |=> rd_data == '0);

  // R8
  stat_hi_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_data[DATA_W-1:NUM_TMR] == '0);

  // R11
  irq_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> $past(acc_en && !acc_wr));

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_flag
    // R6
    flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(flags[i]) |-> $past(running && tick));
    // R9
    flag_fall_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(flags[i]) |-> $past(acc_en && !acc_wr && acc_addr == low_ofs(i)));
  end
endmodule

bind tri_reload_timer tri_reload_timer_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick     (tick),
  .acc_en   (acc_en),
  .acc_wr   (acc_wr),
  .acc_addr (acc_addr),
  .rd_data  (rd_data),
  .irq      (irq),
  .running  (running),
  .flags    (flags)
);

// File: tb/tri_reload_timer_tb.sv
module tri_reload_timer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       acc_en = 1'b0;
  logic       acc_wr = 1'b0;
  logic [2:0] acc_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       irq;

  int checks = 0;
  int errors = 0;
  int ticks  = 0;

  always #4 clk = ~clk;

  tri_reload_timer u_dut (
    .clk(clk), .rst(rst), .tick(tick), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b1; acc_addr = a; wr_data = d;
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, input logic tk, output logic [7:0] d);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b0; acc_addr = a; tick = tk;
    @(negedge clk);
    acc_en = 1'b0; tick = 1'b0;
    if (tk) ticks++;
    d = rd_data;
  endtask

  task automatic tick_n(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
    ticks += n;
  endtask

  task automatic chk_stat(input string req, input int exp);
    logic [7:0] d;
    bus_rd(3'd1, 1'b0, d);
    chk(req, d, exp);
    chk({req, " irq"}, irq, (exp != 0) ? 1 : 0);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 irq", irq, 0);
    chk("R1 rd_data", rd_data, 0);
    chk_stat("R1", 8'h00);
    for (int a = 0; a < 8; a += 2) begin
      bus_rd(3'(a), 1'b0, d);
      chk("R9 unlisted read", d, 0);
    end
  endtask

  task automatic t_prestart();
    bus_wr(3'd1, 8'h41);   // R3 select=1, ie2=1
    bus_wr(3'd0, 8'h41);   // R4 ie1=1, bit0=1 -> no start
    bus_wr(3'd1, 8'h40);   // R3 select=0
    bus_wr(3'd0, 8'h40);   // R5 ie3=1, no start
    tick_n(900);
    chk_stat("R2 no count before start", 8'h00);
    ticks = 0;
  endtask

  task automatic t_start_t1();
    bus_wr(3'd1, 8'h41);
    bus_wr(3'd0, 8'h40);   // R4 start
    tick_n(31);
    chk_stat("R6 t1 before 32", 8'h00);
    tick_n(1);
    chk_stat("R6 R7 R11 t1 at 32", 8'h01);
  endtask

  task automatic t_set_wins();
    logic [7:0] d;
    tick_n(31);
    bus_rd(3'd3, 1'b1, d);  // tick 64 collides with clear
    chk("R9 low byte reads 0", d, 0);
    chk_stat("R10 set wins", 8'h01);
    chk_stat("R8 status no clear", 8'h01);
    bus_rd(3'd3, 1'b0, d);
    chk_stat("R9 t1 cleared", 8'h00);
  endtask

  task automatic t_t3();
    logic [7:0] d;
    tick_n(800 - ticks);
    chk_stat("R6 t3 before 801", 8'h01);
    tick_n(1);
    chk_stat("R6 R7 t3 at 801", 8'h05);
    bus_rd(3'd7, 1'b0, d);
    chk_stat("R9 t3 cleared", 8'h01);
    bus_rd(3'd3, 1'b0, d);
    chk_stat("R9 all cleared", 8'h00);
  endtask

  task automatic t_t2();
    logic [7:0] d;
    tick_n(3199 - ticks);
    chk_stat("R6 t2 before 3200", 8'h05);
    tick_n(1);
    chk_stat("R6 R3 t2 at 3200", 8'h07);
    bus_rd(3'd5, 1'b0, d);
    chk_stat("R9 t2 cleared", 8'h05);
  endtask

  task automatic t_gate_ignore();
    logic [7:0] d;
    bus_rd(3'd3, 1'b0, d);
    bus_rd(3'd7, 1'b0, d);
    bus_wr(3'd0, 8'h00);    // select still 1: ie1=0
    for (int a = 2; a < 8; a++) bus_wr(3'(a), 8'hFF);
    chk_stat("R12 writes ignored flags", 8'h00);
    tick_n(3264 - ticks);
    chk_stat("R7 R12 t1 gated, t3 enabled", 8'h04);
    bus_wr(3'd0, 8'h40);    // select still 1 -> ie1=1
    tick_n(3296 - ticks);
    chk_stat("R12 R4 select kept, t1 re-enabled", 8'h05);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_prestart();
    t_start_t1();
    t_set_wins();
    t_t3();
    t_t2();
    t_gate_ignore();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule